// File: doc/BRIEF.md
# Paged Program Counter and Return Stack Sequencer

This block owns the instruction fetch address of a small 8-bit controller core and the return frames kept on a stack in data RAM. The decoder hands it one command per cycle: a sequential step of one or two bytes, a step that also moves to the next 256-byte page, an absolute jump, a call, an interrupt acknowledge with its vector, a plain return, or a return from interrupt. It also hands it a write of the stack pointer from the accumulator, and the live carry and zero flags. The fetch address is never exposed to ordinary data moves. It changes only through these commands.

The 14-bit address is a 6-bit page over an 8-bit offset. Sequential steps move only the offset, which wraps inside its page. Only the page-advance step moves the page. Calls and interrupt acknowledges push a two-byte frame through a byte-wide RAM port, one byte per cycle. Returns pop the frame with one-cycle-latency reads. While a frame moves, `busy` is high and every incoming command is dropped. The decoder must stall during that time.

The controller has six states. `ST_IDLE` accepts commands. `ST_PUSH_LO` then `ST_PUSH_HI` write the frame. `ST_POP_HI`, `ST_POP_LO` and `ST_POP_END` read it back and reload the address.

The transitions are:
- `ST_IDLE` to `ST_PUSH_LO` on an interrupt acknowledge or a call.
- `ST_IDLE` to `ST_POP_HI` on either kind of return.
- `ST_IDLE` to `ST_IDLE` on any other command or none.
- `ST_PUSH_LO` to `ST_PUSH_HI`, and `ST_PUSH_HI` to `ST_IDLE`.
- `ST_POP_HI` to `ST_POP_LO`, `ST_POP_LO` to `ST_POP_END`, and `ST_POP_END` to `ST_IDLE`, each unconditional.

Top module: `pc_stack_seq`

## Requirements
- R1: While reset is low and after it is released, `fetch_addr` is 0x0000, `sp_out` is 0x00, `busy`, `ram_we`, `ram_re`, `flag_load`, `flag_carry` and `flag_zero` are 0.
- R2: A step (`step_en`) adds 1 (`len_two`=0) or 2 (`len_two`=1) to `fetch_addr[7:0]` modulo 256 at the next clock edge; `fetch_addr[13:8]` is unchanged, including when the offset wraps from 0xFF or 0xFE.
- R3: A page advance (`page_adv`) adds 1 modulo 64 to `fetch_addr[13:8]` and steps `fetch_addr[7:0]` as in R2; no other non-stack command changes `fetch_addr[13:8]` except a jump, call or interrupt.
- R4: A jump loads `jump_addr` into `fetch_addr` at the next edge.
- R5: A call loads `call_addr` into `fetch_addr` at the next edge. It pushes a frame whose return address is the current address with its offset stepped as in R2. The frame's first byte is return address bits 7:0. Its second byte is {carry_in, zero_in, return address bits 13:8}.
- R6: An interrupt acknowledge loads `irq_vec` into `fetch_addr` at the next edge. It pushes a frame laid out as in R5 whose return address is the current `fetch_addr` unchanged.
- R7: A push takes two busy cycles. In each, `ram_we` is 1, `ram_addr` equals `sp_out`, and the edge that ends it increments the stack pointer. The first cycle writes the first byte and the second writes the second.
- R8: A return decrements the stack pointer at the accept edge and again after the first read. It then takes three busy cycles: a read of the second byte, a read of the first byte, and a final cycle. At the edge ending the final cycle, `fetch_addr` becomes {second byte bits 5:0, first byte}. A plain return (`ret_en`) leaves `flag_carry` and `flag_zero` unchanged.
- R9: A return from interrupt (`reti_en`) behaves as R8. In the cycle after its final cycle, `flag_load` is 1 for one cycle and `flag_carry`/`flag_zero` hold bits 7 and 6 of the second byte; otherwise `flag_load` is 0 and both flags hold their values.
- R10: `sp_wr` loads `sp_wdata` into the stack pointer at the next edge. The stack pointer wraps modulo 256 on pushes and pops with no overflow indication.
- R11: While `busy` is 1, every command input, `sp_wr` included, is ignored.
- R12: In `ST_IDLE`, the priority is interrupt acknowledge, then return from interrupt, then return, then call, then jump, then page advance, then step; only the winner acts. `sp_wr` also acts alongside a jump, page advance or step, but not alongside a stack command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Sequential step within the page |
| len_two | input | 1 | Current instruction is two bytes (else one) |
| page_adv | input | 1 | Step and advance to the next page |
| jump_en | input | 1 | Absolute jump |
| jump_addr | input | 14 | Jump target |
| call_en | input | 1 | Call with frame push |
| call_addr | input | 14 | Call target |
| irq_ack | input | 1 | Interrupt acknowledge with frame push |
| irq_vec | input | 14 | Interrupt vector address |
| ret_en | input | 1 | Return, address only |
| reti_en | input | 1 | Return from interrupt, address and flags |
| sp_wr | input | 1 | Write stack pointer from accumulator |
| sp_wdata | input | 8 | Accumulator value for the stack pointer |
| carry_in | input | 1 | Live carry flag |
| zero_in | input | 1 | Live zero flag |
| ram_rdata | input | 8 | Stack RAM read data, one cycle after `ram_re` |
| fetch_addr | output | 14 | Program fetch address |
| ram_addr | output | 8 | Stack RAM address |
| ram_wdata | output | 8 | Stack RAM write data |
| ram_we | output | 1 | Stack RAM write strobe |
| ram_re | output | 1 | Stack RAM read strobe |
| sp_out | output | 8 | Stack pointer |
| busy | output | 1 | Frame transfer in progress |
| flag_carry | output | 1 | Restored carry flag |
| flag_zero | output | 1 | Restored zero flag |
| flag_load | output | 1 | Restored flags are fresh this cycle |

## Verification
The address path is driven with directed offset steps of both lengths near 0xFE/0xFF. This separates an in-page wrap from a carry into the page. Page advances at page 0x3F show the page wrapping on its own.

Calls and interrupts are interleaved with both return kinds and with differing live flags. This shows which frame is popped, that the return address of a call is stepped while that of an interrupt is not, and that only a return from interrupt restores flags.

Simultaneous commands and commands raised during busy cycles separate the priority order from the ignore rule. A stack pointer preset to 0xFF exposes wrap on push and pop.

A long mixed sequence of random commands checks all of these against a behavioural model on every cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int PC_W    = 14;
    localparam int LO_W    = 8;
    localparam int HI_W    = PC_W - LO_W;
    localparam int BYTE_W  = 8;
    localparam int FLAG_W  = 2;
    localparam int FRAME_W = FLAG_W + PC_W;
    localparam int SP_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_HI,
        ST_POP_LO,
        ST_POP_END
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_IRQ,
        CMD_RETI,
        CMD_RET,
        CMD_CALL,
        CMD_JUMP,
        CMD_PAGE,
        CMD_STEP
    } seq_cmd_t;

    typedef enum logic [1:0] {PC_KEEP, PC_STEP, PC_PAGE, PC_LOAD} pc_op_t;
    typedef enum logic [1:0] {SP_KEEP, SP_INC, SP_DEC, SP_LOAD} sp_op_t;
endpackage

// File: rtl/pcs_pc.sv
module pcs_pc
    import pcs_pkg::*;
#(
    parameter int AW  = PC_W,
    parameter int OFW = LO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_op_t        op,
    input  logic          len_two,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] pc
);
    localparam int PGW = AW - OFW;

    logic [AW-1:0]  pc_q;
    logic [AW-1:0]  pc_d;
    logic [OFW-1:0] off_step;
    logic [PGW-1:0] page_next;

    always_comb begin
        off_step  = pc_q[OFW-1:0] + (len_two ? OFW'(2) : OFW'(1));
        page_next = pc_q[AW-1:OFW] + PGW'(1);
        pc_d      = pc_q;
        unique case (op)
            PC_STEP: pc_d = {pc_q[AW-1:OFW], off_step};
            PC_PAGE: pc_d = {page_next, off_step};
            PC_LOAD: pc_d = load_val;
            default: pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;
endmodule

// File: rtl/pcs_sp.sv
module pcs_sp
    import pcs_pkg::*;
#(
    parameter int W = SP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sp_op_t       op,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] sp
);
    logic [W-1:0] sp_q;
    logic [W-1:0] sp_d;

    always_comb begin
        unique case (op)
            SP_INC:  sp_d = sp_q + W'(1);
            SP_DEC:  sp_d = sp_q - W'(1);
            SP_LOAD: sp_d = load_val;
            default: sp_d = sp_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    assign sp = sp_q;
endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              len_two,
    input  logic              page_adv,
    input  logic              jump_en,
    input  logic [PC_W-1:0]   jump_addr,
    input  logic              call_en,
    input  logic [PC_W-1:0]   call_addr,
    input  logic              irq_ack,
    input  logic [PC_W-1:0]   irq_vec,
    input  logic              ret_en,
    input  logic              reti_en,
    input  logic              sp_wr,
    input  logic              carry_in,
    input  logic              zero_in,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [BYTE_W-1:0] ram_rdata,
    output pc_op_t            pc_op,
    output logic [PC_W-1:0]   pc_load,
    output sp_op_t            sp_op,
    output logic              ram_we,
    output logic              ram_re,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic              busy,
    output logic              flag_carry,
    output logic              flag_zero,
    output logic              flag_load
);
    seq_state_t           state_q, state_d;
    seq_cmd_t             cmd;
    logic [FRAME_W-1:0]   frame_q, frame_d;
    logic [BYTE_W-1:0]    hi_q, hi_d;
    logic                 reti_q, reti_d;
    logic                 fc_q, fc_d, fz_q, fz_d, fld_q, fld_d;
    logic [LO_W-1:0]      ret_off;
    logic                 stack_cmd;

    // command arbitration, highest priority first
    always_comb begin
        if (irq_ack)       cmd = CMD_IRQ;
        else if (reti_en)  cmd = CMD_RETI;
        else if (ret_en)   cmd = CMD_RET;
        else if (call_en)  cmd = CMD_CALL;
        else if (jump_en)  cmd = CMD_JUMP;
        else if (page_adv) cmd = CMD_PAGE;
        else if (step_en)  cmd = CMD_STEP;
        else               cmd = CMD_NONE;
        stack_cmd = (cmd == CMD_IRQ) || (cmd == CMD_RETI) ||
                    (cmd == CMD_RET) || (cmd == CMD_CALL);
        ret_off   = pc_cur[LO_W-1:0] + (len_two ? LO_W'(2) : LO_W'(1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            frame_q <= '0;
            hi_q    <= '0;
            reti_q  <= 1'b0;
            fc_q    <= 1'b0;
            fz_q    <= 1'b0;
            fld_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            frame_q <= frame_d;
            hi_q    <= hi_d;
            reti_q  <= reti_d;
            fc_q    <= fc_d;
            fz_q    <= fz_d;
            fld_q   <= fld_d;
        end
    end

    // transitions and held data
    always_comb begin
        state_d = state_q;
        frame_d = frame_q;
        hi_d    = hi_q;
        reti_d  = reti_q;
        fc_d    = fc_q;
        fz_d    = fz_q;
        fld_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                unique case (cmd)
                    CMD_IRQ: begin
                        frame_d = {carry_in, zero_in, pc_cur};
                        state_d = ST_PUSH_LO;
                    end
                    CMD_CALL: begin
                        frame_d = {carry_in, zero_in, pc_cur[PC_W-1:LO_W], ret_off};
                        state_d = ST_PUSH_LO;
                    end
                    CMD_RETI: begin
                        reti_d  = 1'b1;
                        state_d = ST_POP_HI;
                    end
                    CMD_RET: begin
                        reti_d  = 1'b0;
                        state_d = ST_POP_HI;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
            ST_PUSH_LO: state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_IDLE;
            ST_POP_HI:  state_d = ST_POP_LO;
            ST_POP_LO: begin
                hi_d    = ram_rdata;
                state_d = ST_POP_END;
            end
            ST_POP_END: begin
                if (reti_q) begin
                    fc_d  = hi_q[BYTE_W-1];
                    fz_d  = hi_q[BYTE_W-2];
                    fld_d = 1'b1;
                end
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs per state
    always_comb begin
        pc_op     = PC_KEEP;
        pc_load   = '0;
        sp_op     = SP_KEEP;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                unique case (cmd)
                    CMD_IRQ:  begin pc_op = PC_LOAD; pc_load = irq_vec;   end
                    CMD_CALL: begin pc_op = PC_LOAD; pc_load = call_addr; end
                    CMD_JUMP: begin pc_op = PC_LOAD; pc_load = jump_addr; end
                    CMD_RETI: sp_op = SP_DEC;
                    CMD_RET:  sp_op = SP_DEC;
                    CMD_PAGE: pc_op = PC_PAGE;
                    CMD_STEP: pc_op = PC_STEP;
                    default:  pc_op = PC_KEEP;
                endcase
                if (sp_wr && !stack_cmd) sp_op = SP_LOAD;
            end
            ST_PUSH_LO: begin
                ram_we    = 1'b1;
                ram_wdata = frame_q[BYTE_W-1:0];
                sp_op     = SP_INC;
            end
            ST_PUSH_HI: begin
                ram_we    = 1'b1;
                ram_wdata = frame_q[FRAME_W-1:BYTE_W];
                sp_op     = SP_INC;
            end
            ST_POP_HI: begin
                ram_re = 1'b1;
                sp_op  = SP_DEC;
            end
            ST_POP_LO: ram_re = 1'b1;
            ST_POP_END: begin
                pc_op   = PC_LOAD;
                pc_load = {hi_q[HI_W-1:0], ram_rdata};
            end
            default: pc_op = PC_KEEP;
        endcase
    end

    assign busy       = (state_q != ST_IDLE);
    assign flag_carry = fc_q;
    assign flag_zero  = fz_q;
    assign flag_load  = fld_q;
endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              len_two,
    input  logic              page_adv,
    input  logic              jump_en,
    input  logic [PC_W-1:0]   jump_addr,
    input  logic              call_en,
    input  logic [PC_W-1:0]   call_addr,
    input  logic              irq_ack,
    input  logic [PC_W-1:0]   irq_vec,
    input  logic              ret_en,
    input  logic              reti_en,
    input  logic              sp_wr,
    input  logic [SP_W-1:0]   sp_wdata,
    input  logic              carry_in,
    input  logic              zero_in,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic [PC_W-1:0]   fetch_addr,
    output logic [SP_W-1:0]   ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              ram_re,
    output logic [SP_W-1:0]   sp_out,
    output logic              busy,
    output logic              flag_carry,
    output logic              flag_zero,
    output logic              flag_load
);
    pc_op_t          pc_op;
    sp_op_t          sp_op;
    logic [PC_W-1:0] pc_load;
    logic [PC_W-1:0] pc_val;
    logic [SP_W-1:0] sp_val;

    pcs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .len_two    (len_two),
        .page_adv   (page_adv),
        .jump_en    (jump_en),
        .jump_addr  (jump_addr),
        .call_en    (call_en),
        .call_addr  (call_addr),
        .irq_ack    (irq_ack),
        .irq_vec    (irq_vec),
        .ret_en     (ret_en),
        .reti_en    (reti_en),
        .sp_wr      (sp_wr),
        .carry_in   (carry_in),
        .zero_in    (zero_in),
        .pc_cur     (pc_val),
        .ram_rdata  (ram_rdata),
        .pc_op      (pc_op),
        .pc_load    (pc_load),
        .sp_op      (sp_op),
        .ram_we     (ram_we),
        .ram_re     (ram_re),
        .ram_wdata  (ram_wdata),
        .busy       (busy),
        .flag_carry (flag_carry),
        .flag_zero  (flag_zero),
        .flag_load  (flag_load)
    );

    pcs_pc #(.AW(PC_W), .OFW(LO_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (pc_op),
        .len_two  (len_two),
        .load_val (pc_load),
        .pc       (pc_val)
    );

    pcs_sp #(.W(SP_W)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (sp_op),
        .load_val (sp_wdata),
        .sp       (sp_val)
    );

    assign fetch_addr = pc_val;
    assign sp_out     = sp_val;
    assign ram_addr   = sp_val;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
    import pcs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              page_adv,
    input logic              jump_en,
    input logic              call_en,
    input logic              irq_ack,
    input logic [PC_W-1:0]   fetch_addr,
    input logic [SP_W-1:0]   sp_out,
    input logic              ram_we,
    input logic              ram_re,
    input logic              busy,
    input logic              flag_carry,
    input logic              flag_zero,
    input logic              flag_load
);
    a_r7_push_increments_sp: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> sp_out == $past(sp_out) + 8'd1);

    a_r8_read_after_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |-> sp_out == $past(sp_out) - 8'd1);

    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    a_r11_addr_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fetch_addr));

    a_r9_flags_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_load |-> ($stable(flag_carry) && $stable(flag_zero)));

    a_r9_load_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |-> ($past(busy) && !busy && !$past(ram_re)));

    a_r3_page_moves_on_command: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr[PC_W-1:LO_W] != $past(fetch_addr[PC_W-1:LO_W])) |->
        $past(page_adv || jump_en || call_en || irq_ack || busy));
endmodule

bind pc_stack_seq pcs_checker u_pcs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .page_adv   (page_adv),
    .jump_en    (jump_en),
    .call_en    (call_en),
    .irq_ack    (irq_ack),
    .fetch_addr (fetch_addr),
    .sp_out     (sp_out),
    .ram_we     (ram_we),
    .ram_re     (ram_re),
    .busy       (busy),
    .flag_carry (flag_carry),
    .flag_zero  (flag_zero),
    .flag_load  (flag_load)
);

// File: tb/pc_stack_seq_test.sv
`timescale 1ns/1ps
module pc_stack_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic step_en, len_two, page_adv, jump_en, call_en, irq_ack, ret_en, reti_en, sp_wr;
    logic carry_in, zero_in;
    logic [13:0] jump_addr, call_addr, irq_vec;
    logic [7:0]  sp_wdata;
    logic [7:0]  ram_rdata;
    logic [13:0] fetch_addr;
    logic [7:0]  ram_addr, ram_wdata, sp_out;
    logic ram_we, ram_re, busy, flag_carry, flag_zero, flag_load;

    pc_stack_seq uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .len_two(len_two),
        .page_adv(page_adv), .jump_en(jump_en), .jump_addr(jump_addr),
        .call_en(call_en), .call_addr(call_addr), .irq_ack(irq_ack),
        .irq_vec(irq_vec), .ret_en(ret_en), .reti_en(reti_en), .sp_wr(sp_wr),
        .sp_wdata(sp_wdata), .carry_in(carry_in), .zero_in(zero_in),
        .ram_rdata(ram_rdata), .fetch_addr(fetch_addr), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
        .sp_out(sp_out), .busy(busy), .flag_carry(flag_carry),
        .flag_zero(flag_zero), .flag_load(flag_load)
    );

    // stack RAM with one-cycle read latency
    logic [7:0] ram [256];
    always @(posedge clk) begin
        if (ram_we) ram[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= ram[ram_addr];
    end

    int checks = 0;
    int errors = 0;
    string scen = "R1";

    task automatic chk(input string field, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", scen, field, act, exp);
        end
    endtask

    // behavioural reference model
    logic [13:0] m_pc;
    logic [7:0]  m_sp, m_base;
    logic        m_cf, m_zf, m_fl, m_reti;
    int          m_kind;   // 0 idle, 1 pushing, 2 popping
    int          m_j;
    logic [15:0] m_frame;
    logic [7:0]  m_mem [256];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc = '0; m_sp = '0; m_cf = 0; m_zf = 0; m_fl = 0;
            m_kind = 0; m_j = 0; m_reti = 0; m_frame = '0; m_base = '0;
        end else begin
            m_fl = 1'b0;
            if (m_kind == 1) begin
                m_mem[m_sp] = (m_j == 0) ? m_frame[7:0] : m_frame[15:8];
                m_sp = m_sp + 8'd1;
                m_j++;
                if (m_j == 2) m_kind = 0;
            end else if (m_kind == 2) begin
                if (m_j == 0) m_sp = m_sp - 8'd1;
                m_j++;
                if (m_j == 3) begin
                    logic [7:0] hb, lb;
                    hb = m_mem[m_base - 8'd1];
                    lb = m_mem[m_base - 8'd2];
                    m_pc = {hb[5:0], lb};
                    if (m_reti) begin
                        m_cf = hb[7]; m_zf = hb[6]; m_fl = 1'b1;
                    end
                    m_kind = 0;
                end
            end else begin
                logic stk;
                logic [7:0] nlo;
                stk = irq_ack | reti_en | ret_en | call_en;
                nlo = m_pc[7:0] + (len_two ? 8'd2 : 8'd1);
                if (irq_ack) begin
                    m_frame = {carry_in, zero_in, m_pc};
                    m_pc = irq_vec; m_kind = 1; m_j = 0;
                end else if (reti_en || ret_en) begin
                    m_reti = reti_en; m_base = m_sp;
                    m_sp = m_sp - 8'd1; m_kind = 2; m_j = 0;
                end else if (call_en) begin
                    m_frame = {carry_in, zero_in, m_pc[13:8], nlo};
                    m_pc = call_addr; m_kind = 1; m_j = 0;
                end else if (jump_en) m_pc = jump_addr;
                else if (page_adv)    m_pc = {m_pc[13:8] + 6'd1, nlo};
                else if (step_en)     m_pc = {m_pc[13:8], nlo};
                if (sp_wr && !stk) m_sp = sp_wdata;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        logic exp_we, exp_re;
        exp_we = (m_kind == 1);
        exp_re = (m_kind == 2) && (m_j < 2);
        chk("fetch_addr", fetch_addr, m_pc);
        chk("sp_out", sp_out, m_sp);
        chk("busy", busy, m_kind != 0);
        chk("ram_we", ram_we, exp_we);
        chk("ram_re", ram_re, exp_re);
        if (exp_we || exp_re) chk("ram_addr", ram_addr, m_sp);
        if (exp_we) chk("ram_wdata", ram_wdata, (m_j == 0) ? m_frame[7:0] : m_frame[15:8]);
        chk("flag_carry", flag_carry, m_cf);
        chk("flag_zero", flag_zero, m_zf);
        chk("flag_load", flag_load, m_fl);
    end

    task automatic clr();
        step_en = 0; len_two = 0; page_adv = 0; jump_en = 0; call_en = 0;
        irq_ack = 0; ret_en = 0; reti_en = 0; sp_wr = 0;
    endtask

    task automatic go(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            clr();
        end
    endtask

    task automatic jmp(input logic [13:0] a);
        jump_en = 1; jump_addr = a; go();
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i] = 8'(i ^ 8'h5A);
            m_mem[i] = 8'(i ^ 8'h5A);
        end
        ram_rdata = '0;
        clr();
        carry_in = 0; zero_in = 0;
        jump_addr = '0; call_addr = '0; irq_vec = '0; sp_wdata = '0;
        scen = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        go(3);

        scen = "R2";
        step_en = 1; go();
        step_en = 1; len_two = 1; go();
        jmp(14'h00FE);
        step_en = 1; len_two = 1; go();
        jmp(14'h12FF);
        step_en = 1; go();
        jmp(14'h12FE);
        step_en = 1; go();
        step_en = 1; go();
        go(1);

        scen = "R3";
        jmp(14'h12FF);
        page_adv = 1; go();
        jmp(14'h3FFE);
        page_adv = 1; len_two = 1; go();
        page_adv = 1; go();
        go(1);

        scen = "R4";
        jmp(14'h2A55);
        jmp(14'h0001);
        go(1);

        scen = "R5";
        jmp(14'h05FE);
        carry_in = 1; zero_in = 0;
        call_en = 1; call_addr = 14'h1234; len_two = 1; go();
        go(3);
        scen = "R6";
        carry_in = 0; zero_in = 1;
        irq_ack = 1; irq_vec = 14'h0010; go();
        go(3);
        scen = "R8";
        carry_in = 1; zero_in = 1;
        ret_en = 1; go();
        go(4);
        scen = "R9";
        reti_en = 1; go();
        go(4);

        scen = "R10";
        sp_wdata = 8'hFF; sp_wr = 1; go();
        carry_in = 0; zero_in = 1;
        call_en = 1; call_addr = 14'h0300; go();
        go(3);
        reti_en = 1; go();
        go(4);

        scen = "R7";
        sp_wdata = 8'h40; sp_wr = 1; go();
        call_en = 1; call_addr = 14'h2000; go();
        go(3);

        scen = "R11";
        call_en = 1; call_addr = 14'h0700; go();
        jump_en = 1; jump_addr = 14'h1111; step_en = 1; sp_wr = 1; sp_wdata = 8'h22; go();
        ret_en = 1; page_adv = 1; go();
        go(2);
        reti_en = 1; go();
        call_en = 1; irq_ack = 1; sp_wr = 1; go();
        jump_en = 1; jump_addr = 14'h0AAA; go();
        step_en = 1; go();
        go(2);

        scen = "R12";
        irq_ack = 1; irq_vec = 14'h0020; call_en = 1; call_addr = 14'h0400;
        jump_en = 1; jump_addr = 14'h0500; go();
        go(3);
        ret_en = 1; call_en = 1; call_addr = 14'h0600; go();
        go(4);
        jump_en = 1; jump_addr = 14'h0880; step_en = 1; page_adv = 1; go();
        page_adv = 1; step_en = 1; go();
        sp_wr = 1; sp_wdata = 8'h10; step_en = 1; go();
        sp_wr = 1; sp_wdata = 8'h90; call_en = 1; call_addr = 14'h0123; go();
        go(3);
        reti_en = 1; ret_en = 1; go();
        go(4);

        scen = "R12";
        for (int k = 0; k < 2000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            carry_in = 1'($urandom); zero_in = 1'($urandom);
            len_two = 1'($urandom);
            jump_addr = 14'($urandom); call_addr = 14'($urandom);
            irq_vec = 14'($urandom); sp_wdata = 8'($urandom);
            irq_ack = (r < 5);
            call_en = (r >= 5 && r < 12);
            ret_en  = (r >= 12 && r < 18);
            reti_en = (r >= 18 && r < 23);
            jump_en = (r >= 23 && r < 30) || (r > 95);
            page_adv = (r >= 30 && r < 38);
            step_en = (r >= 38 && r < 80) || (r > 90);
            sp_wr   = (r >= 80 && r < 84) || (r == 99);
            go();
        end
        go(6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule